// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a memory-mapped general-purpose timer. A 32-bit up-counter advances on a count tick that is chosen from one of three single-cycle enable inputs: a bus-clock enable, a peripheral-clock enable and an oscillator enable. The bus and peripheral paths share a 12-bit main divider. The oscillator path has its own 4-bit divider, which is switched on by a dedicated control bit. All sources are treated as enables inside a single clock domain.

A single compare channel sets a sticky flag when the counter steps onto the compare value. The interrupt output is that flag masked by an enable bit. Software clears the flag by writing 1 to it. Two counting modes exist:

- **Free-run:** the counter runs past a match and wraps modulo 2^32.
- **Restart:** the counter returns to 0 on the tick after it reaches the compare value.

Software reads and writes the registers through a plain address / write-enable / data bus. Reads are combinational.

Top module: `tmr_top`

## Requirements
- R1: After reset every register reads 0, the counter reads 0, and `irq` is low.
- R2: Register offsets and readback:
  - Control is at 0x00. Bit 0 = run enable. Bit 3 = keep counting in wait mode. Bits 8:6 = source code. Bit 9 = free-run. Bit 10 = oscillator divider enable. Other control bits read as 0.
  - Prescale is at 0x04. Bits 11:0 = main divide. Bits 15:12 = oscillator divide. Other bits read as 0.
  - Status is at 0x08, bit 0 only.
  - Interrupt enable is at 0x0C, bit 0 only.
  - Compare is at 0x10 and is 32 bits wide.
  - Counter is at 0x24 and is read-only.
- R3: While control bit 0 is 0, the counter holds its value. A control write that takes bit 0 from 0 to 1 clears the counter and both prescaler counters to 0.
- R4: Source code 1 counts `bus_tick`, code 2 counts `per_tick`, and code 5 counts `osc_tick`. Every other source code produces no count.
- R5: With code 1 or 2, the counter advances once for every (main divide + 1) enables of the selected input.
- R6: With code 5, the divide ratio depends only on bit 10. If bit 10 is set, the counter advances once per (oscillator divide + 1) `osc_tick` enables. If bit 10 is clear, it advances once per `osc_tick` enable. The main divide field has no effect on code 5.
- R7: While `wait_mode` is high and control bit 3 is 0, counting and prescaling are frozen. With bit 3 set, counting continues in wait mode.
- R8: The status flag is set on the tick where the counter changes to a value equal to the compare register. Matching is by exact equality, so a compare value below the current count does not set the flag until the counter wraps.
- R9: In free-run mode a match does not disturb counting. In restart mode, the tick after the counter equals the compare value loads 0, so after n ticks from 0 the counter reads n mod (compare + 1).
- R10: Writing 1 to status bit 0 clears the flag. Writing 0 has no effect. A set and a clear in the same cycle leave the flag set.
- R11: `irq` equals status bit 0 AND interrupt-enable bit 0. It stays high until the flag is cleared or the enable is written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bus_tick | input | 1 | Bus-clock count enable |
| per_tick | input | 1 | Peripheral-clock count enable |
| osc_tick | input | 1 | Oscillator count enable |
| wait_mode | input | 1 | System is in wait mode |
| irq | output | 1 | Level compare interrupt |

## Verification
A wrong prescaler or source-select state appears as a counter value that differs from enables/(ratio) at the next read, within one divide period. A stale enable edge shows as a non-zero counter read in the cycle right after the enable write. A missed or spurious match shows on status and `irq` on the very tick the counter steps onto the compare value. A restart fault shows one tick later as a counter that fails to return to 0.

// File: rtl/tmr_pkg.sv
// Shared offsets, bit positions and types for the compare timer.
// Assumes a byte-addressed register bus with 32-bit data.
package tmr_pkg;
    localparam int OFS_CTRL = 'h00;
    localparam int OFS_PRE  = 'h04;
    localparam int OFS_STAT = 'h08;
    localparam int OFS_IER  = 'h0C;
    localparam int OFS_CMP  = 'h10;
    localparam int OFS_CNT  = 'h24;

    localparam int CB_EN     = 0;
    localparam int CB_WAIT   = 3;
    localparam int CB_SRC_LO = 6;
    localparam int CB_FRR    = 9;
    localparam int CB_OSC    = 10;
    localparam int PB_OSC_LO = 12;

    localparam logic [2:0] SRC_BUS = 3'd1;
    localparam logic [2:0] SRC_PER = 3'd2;
    localparam logic [2:0] SRC_OSC = 3'd5;

    typedef struct packed {
        logic       osc_en;
        logic       frr;
        logic [2:0] src;
        logic       waiten;
        logic       en;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_div.sv
// Modulo prescaler. It emits a pulse on every (limit+1)-th advance.
// Assumes a lowered limit must not stall it, so >= is used for the terminal test.
module tmr_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] limit,
    output logic         pulse
);
    logic [W-1:0] pcnt_q;

    assign pulse = adv && (pcnt_q >= limit);

    // Advance the phase counter and restart it on the terminal count or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     pcnt_q <= '0;
        else if (clr)   pcnt_q <= '0;
        else if (adv)   pcnt_q <= pulse ? '0 : pcnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr_prescale.sv
// Source selection and the two prescalers. The output is the counter tick.
// Assumes all sources are single-cycle enables in the clk domain.
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int MPRE_W = 12,
    parameter int OPRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [2:0]        src,
    input  logic              osc_en,
    input  logic [MPRE_W-1:0] main_div,
    input  logic [OPRE_W-1:0] osc_div,
    input  logic              bus_tick,
    input  logic              per_tick,
    input  logic              osc_tick,
    output logic              cnt_tick
);
    logic              main_in, main_pulse, osc_pulse;
    logic [OPRE_W-1:0] osc_lim;

    // Route the bus or peripheral enable into the main divider.
    always_comb begin
        unique case (src)
            SRC_BUS: main_in = bus_tick;
            SRC_PER: main_in = per_tick;
            default: main_in = 1'b0;
        endcase
    end

    assign osc_lim = osc_en ? osc_div : '0;

    tmr_div #(.W(MPRE_W)) u_main_div (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .adv(run && main_in), .limit(main_div), .pulse(main_pulse)
    );

    tmr_div #(.W(OPRE_W)) u_osc_div (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .adv(run && (src == SRC_OSC) && osc_tick), .limit(osc_lim), .pulse(osc_pulse)
    );

    assign cnt_tick = main_pulse || osc_pulse;

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> run); // R7
    AST_TICK_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> (src == SRC_BUS || src == SRC_PER || src == SRC_OSC)); // R4
endmodule

// File: rtl/tmr_count.sv
// 32-bit up-counter with a compare match and a sticky status flag.
// Assumes at most one tick per cycle and a clear that has priority over the tick.
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_tick,
    input  logic             frr,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cmp_flag
);
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = (!frr && (cnt_q == cmp_val)) ? '0 : cnt_q + 1'b1;

    // Step the counter on each tick, or zero it on a start clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr)      cnt_q <= '0;
        else if (cnt_tick) cnt_q <= cnt_nxt;
    end

    // Set the flag on a match tick. The set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        cmp_flag <= 1'b0;
        else if (cnt_tick && !clr && (cnt_nxt == cmp_val)) cmp_flag <= 1'b1;
        else if (flag_clr)                                 cmp_flag <= 1'b0;
    end

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !clr) |=> $stable(cnt_q)); // R3
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !clr && frr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_FLAG_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag) |-> (cnt_q == cmp_val || !$stable(cmp_val))); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cnt_tick) |=> !cmp_flag); // R10
endmodule

// File: rtl/tmr_regs.sv
// Register file and read mux for the timer.
// Assumes one write per cycle. Reads are combinational on bus_addr.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int MPRE_W = 12,
    parameter int OPRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              cmp_flag,
    output tmr_ctrl_t         ctrl,
    output logic [MPRE_W-1:0] main_div,
    output logic [OPRE_W-1:0] osc_div,
    output logic              ier_en,
    output logic [CNT_W-1:0]  cmp_val,
    output logic              flag_clr,
    output logic              start_clr
);
    logic wr_ctrl, wr_pre, wr_stat, wr_ier, wr_cmp;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_pre  = bus_wr && (bus_addr == ADDR_W'(OFS_PRE));
    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_ier  = bus_wr && (bus_addr == ADDR_W'(OFS_IER));
    assign wr_cmp  = bus_wr && (bus_addr == ADDR_W'(OFS_CMP));

    assign flag_clr  = wr_stat && bus_wdata[0];
    assign start_clr = wr_ctrl && bus_wdata[CB_EN] && !ctrl.en;

    // Hold the control, prescale, interrupt-enable and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            main_div <= '0;
            osc_div  <= '0;
            ier_en   <= 1'b0;
            cmp_val  <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.en     <= bus_wdata[CB_EN];
                ctrl.waiten <= bus_wdata[CB_WAIT];
                ctrl.src    <= bus_wdata[CB_SRC_LO +: 3];
                ctrl.frr    <= bus_wdata[CB_FRR];
                ctrl.osc_en <= bus_wdata[CB_OSC];
            end
            if (wr_pre) begin
                main_div <= bus_wdata[MPRE_W-1:0];
                osc_div  <= bus_wdata[PB_OSC_LO +: OPRE_W];
            end
            if (wr_ier) ier_en  <= bus_wdata[0];
            if (wr_cmp) cmp_val <= bus_wdata;
        end
    end

    // Select the register addressed by bus_addr for read-back.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[CB_EN]           = ctrl.en;
                bus_rdata[CB_WAIT]         = ctrl.waiten;
                bus_rdata[CB_SRC_LO +: 3]  = ctrl.src;
                bus_rdata[CB_FRR]          = ctrl.frr;
                bus_rdata[CB_OSC]          = ctrl.osc_en;
            end
            ADDR_W'(OFS_PRE): begin
                bus_rdata[MPRE_W-1:0]          = main_div;
                bus_rdata[PB_OSC_LO +: OPRE_W] = osc_div;
            end
            ADDR_W'(OFS_STAT): bus_rdata[0] = cmp_flag;
            ADDR_W'(OFS_IER):  bus_rdata[0] = ier_en;
            ADDR_W'(OFS_CMP):  bus_rdata = cmp_val;
            ADDR_W'(OFS_CNT):  bus_rdata = cnt_val;
            default:           bus_rdata = '0;
        endcase
    end

    AST_START_ONLY_FROM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        start_clr |=> ctrl.en); // R3
endmodule

// File: rtl/tmr_top.sv
// Free-running compare timer: registers, prescalers, counter and interrupt.
// Assumes a single clock domain with the count sources given as enables.
module tmr_top
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int MPRE_W = 12,
    parameter int OPRE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              bus_tick,
    input  logic              per_tick,
    input  logic              osc_tick,
    input  logic              wait_mode,
    output logic              irq
);
    tmr_ctrl_t         ctrl;
    logic [MPRE_W-1:0] main_div;
    logic [OPRE_W-1:0] osc_div;
    logic [CNT_W-1:0]  cmp_val, cnt_val;
    logic              ier_en, flag_clr, start_clr, cmp_flag, cnt_tick, run;

    tmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MPRE_W(MPRE_W), .OPRE_W(OPRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
        .cmp_flag(cmp_flag), .ctrl(ctrl), .main_div(main_div), .osc_div(osc_div),
        .ier_en(ier_en), .cmp_val(cmp_val), .flag_clr(flag_clr), .start_clr(start_clr)
    );

    assign run = ctrl.en && (ctrl.waiten || !wait_mode);

    tmr_prescale #(.MPRE_W(MPRE_W), .OPRE_W(OPRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(start_clr), .src(ctrl.src),
        .osc_en(ctrl.osc_en), .main_div(main_div), .osc_div(osc_div),
        .bus_tick(bus_tick), .per_tick(per_tick), .osc_tick(osc_tick),
        .cnt_tick(cnt_tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start_clr), .cnt_tick(cnt_tick),
        .frr(ctrl.frr), .cmp_val(cmp_val), .flag_clr(flag_clr),
        .cnt_q(cnt_val), .cmp_flag(cmp_flag)
    );

    assign irq = cmp_flag && ier_en;

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(bus_wr && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0])
             && !(bus_wr && (bus_addr == ADDR_W'(OFS_IER)))) |=> irq); // R11
    AST_IRQ_OFF_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1
endmodule

// File: tb/tmr_top_bench.sv
module tmr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_tick = 1'b0, per_tick = 1'b0, osc_tick = 1'b0, wait_mode = 1'b0;
    logic        irq;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    localparam logic [7:0] A_CTRL = 8'h00, A_PRE = 8'h04, A_STAT = 8'h08,
                           A_IER = 8'h0C, A_CMP = 8'h10, A_CNT = 8'h24;
    localparam logic [31:0] EN = 32'h1, WAITEN = 32'h8, FRR = 32'h200, OSCEN = 32'h400;

    tmr_top u_tmr_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_tick(bus_tick),
        .per_tick(per_tick), .osc_tick(osc_tick), .wait_mode(wait_mode), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] src_bits(input int code);
        return 32'(code) << 6;
    endfunction
    function automatic int div_count(input int n, input int ratio);
        return n / ratio;
    endfunction
    function automatic int restart_count(input int n, input int cmp);
        return n % (cmp + 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n, input int pct, output int ni, output int np, output int no);
        ni = 0; np = 0; no = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_tick = (int'($urandom_range(99)) < pct);
            per_tick = (int'($urandom_range(99)) < pct);
            osc_tick = (int'($urandom_range(99)) < pct);
            if (bus_tick) ni++;
            if (per_tick) np++;
            if (osc_tick) no++;
        end
        @(negedge clk);
        bus_tick = 1'b0; per_tick = 1'b0; osc_tick = 1'b0;
    endtask

    task automatic restart_timer(input logic [31:0] ctrl_val);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, ctrl_val);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int ni, np, no;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 0);
        rd(A_PRE, d);  check("R1 pre", d, 0);
        rd(A_STAT, d); check("R1 stat", d, 0);
        rd(A_IER, d);  check("R1 ier", d, 0);
        rd(A_CMP, d);  check("R1 cmp", d, 0);
        rd(A_CNT, d);  check("R1 cnt", d, 0);
        check("R1 irq", irq, 0);

        // R2 readback masks
        wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); check("R2 ctrl mask", d, 32'h7C9);
        wr(A_CTRL, 0);
        wr(A_PRE, 32'hFFFF_FFFF); rd(A_PRE, d); check("R2 pre mask", d, 32'hFFFF);
        wr(A_IER, 32'hFFFF_FFFF); rd(A_IER, d); check("R2 ier mask", d, 1);
        wr(A_IER, 0);
        wr(A_CMP, 32'hA5C3_0F1E); rd(A_CMP, d); check("R2 cmp", d, 32'hA5C3_0F1E);
        wr(A_CMP, 32'hFFFF_FFFF);

        // R5 random main prescale on bus and peripheral sources
        for (int k = 0; k < 6; k++) begin
            int dv, code, pct;
            dv = int'($urandom_range(7));
            code = (k % 2 == 1) ? 2 : 1;
            pct = int'($urandom_range(90, 30));
            wr(A_CTRL, 0);
            wr(A_PRE, 32'(dv));
            wr(A_CTRL, EN | FRR | src_bits(code));
            run_ticks(120, pct, ni, np, no);
            rd(A_CNT, d);
            check("R5 main divide", d, 32'(div_count(code == 1 ? ni : np, dv + 1)));
        end

        // R4 unused source code gives no count, code 2 counts per_tick
        wr(A_PRE, 0);
        restart_timer(EN | FRR | src_bits(3));
        run_ticks(40, 100, ni, np, no);
        rd(A_CNT, d); check("R4 code3 no count", d, 0);
        restart_timer(EN | FRR | src_bits(2));
        run_ticks(60, 50, ni, np, no);
        rd(A_CNT, d); check("R4 code2 per", d, 32'(np));

        // R6 oscillator divider, main field ignored
        wr(A_PRE, (32'd3 << 12) | 32'd5);
        restart_timer(EN | FRR | OSCEN | src_bits(5));
        run_ticks(100, 60, ni, np, no);
        rd(A_CNT, d); check("R6 osc divide", d, 32'(div_count(no, 4)));
        restart_timer(EN | FRR | src_bits(5));
        run_ticks(50, 60, ni, np, no);
        rd(A_CNT, d); check("R6 osc undivided", d, 32'(no));

        // R7 wait mode
        wr(A_PRE, 0);
        restart_timer(EN | FRR | src_bits(1));
        wait_mode = 1'b1;
        run_ticks(40, 100, ni, np, no);
        rd(A_CNT, d); check("R7 frozen in wait", d, 0);
        wr(A_CTRL, EN | WAITEN | FRR | src_bits(1));
        run_ticks(30, 100, ni, np, no);
        rd(A_CNT, d); check("R7 waiten counts", d, 30);
        wait_mode = 1'b0;

        // R3 hold while off, clear on enable edge (counter and prescaler)
        wr(A_CTRL, FRR | src_bits(1));
        run_ticks(20, 100, ni, np, no);
        rd(A_CNT, d); check("R3 hold when off", d, 30);
        wr(A_CTRL, EN | FRR | src_bits(1));
        rd(A_CNT, d); check("R3 clear on enable", d, 0);
        wr(A_PRE, 3);
        restart_timer(EN | FRR | src_bits(1));
        run_ticks(2, 100, ni, np, no);
        restart_timer(EN | FRR | src_bits(1));
        run_ticks(2, 100, ni, np, no);
        rd(A_CNT, d); check("R3 prescaler cleared", d, 0);

        // R8 R9 R10 R11 compare, free-run
        wr(A_PRE, 0);
        wr(A_CMP, 10);
        restart_timer(EN | FRR | src_bits(1));
        run_ticks(9, 100, ni, np, no);
        rd(A_STAT, d); check("R8 no flag before match", d, 0);
        run_ticks(1, 100, ni, np, no);
        rd(A_STAT, d); check("R8 flag at match", d, 1);
        rd(A_CNT, d);  check("R8 count at match", d, 10);
        check("R11 irq masked", irq, 0);
        wr(A_IER, 1);
        check("R11 irq on", irq, 1);
        run_ticks(5, 100, ni, np, no);
        rd(A_CNT, d); check("R9 free-run continues", d, 15);
        check("R11 irq held", irq, 1);
        wr(A_STAT, 0);
        rd(A_STAT, d); check("R10 write 0 no effect", d, 1);
        wr(A_STAT, 1);
        rd(A_STAT, d); check("R10 write 1 clears", d, 0);
        check("R11 irq follows clear", irq, 0);
        wr(A_CMP, 16);
        @(negedge clk);
        bus_tick = 1'b1; bus_addr = A_STAT; bus_wdata = 1; bus_wr = 1'b1;
        @(negedge clk);
        bus_tick = 1'b0; bus_wr = 1'b0;
        rd(A_STAT, d); check("R10 set wins over clear", d, 1);
        wr(A_STAT, 1);
        wr(A_CMP, 13);
        run_ticks(50, 100, ni, np, no);
        rd(A_STAT, d); check("R8 behind count no match", d, 0);
        rd(A_CNT, d);  check("R8 count past compare", d, 66);
        wr(A_IER, 0);

        // R9 restart mode
        wr(A_CMP, 4);
        restart_timer(EN | src_bits(1));
        run_ticks(5, 100, ni, np, no);
        rd(A_CNT, d);  check("R9 restart to zero", d, 0);
        rd(A_STAT, d); check("R8 flag in restart", d, 1);
        run_ticks(7, 100, ni, np, no);
        rd(A_CNT, d);  check("R9 restart modulo", d, 32'(restart_count(12, 4)));
        wr(A_CMP, 6);
        restart_timer(EN | src_bits(2));
        run_ticks(80, 70, ni, np, no);
        rd(A_CNT, d);  check("R9 random restart", d, 32'(restart_count(np, 6)));

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule